// File: doc/BRIEF.md
# Atomic Memory Operation Unit

This unit sits in front of a small word-addressed memory and carries out synchronization operations for several requesters: fetch-and-add, compare-and-swap, and a load-linked / store-conditional pair. It also takes plain loads and stores, and a plain store can break a link. Each requester drives its own request channel with a valid/ready handshake. The channel carries an opcode, a word address and two operands. At most one read-modify-write is in progress at any time, so every operation is indivisible from the point of view of every requester.

Each requester has one link reservation, made of a valid bit and an address. A write to a word by any operation clears every reservation that points at that word. A store-conditional whose own reservation no longer matches therefore fails and leaves memory unchanged. Responses come back on a single shared channel. Each response carries the requester number, the value the word held before the operation, and a success flag for the conditional operations.

Top module: `atomic_unit`

## Requirements
- R1: When several requesters are valid in the same cycle and the unit is idle, only the lowest-numbered valid requester sees ready. At most one request is accepted per cycle.
- R2: Requests are accepted on a clock edge where valid and ready are both high. In the cycle after an acceptance, no requester sees ready. The response for that request is valid for exactly one cycle, starting after the second clock edge that follows the acceptance, and it carries the requester's number.
- R3: Fetch-and-add (opcode 2) writes the old word plus operand A, wrapping modulo 2^DATA_W. It returns the old word with the success flag low.
- R4: Compare-and-swap (opcode 3) writes operand B only when the old word equals operand A. It always returns the old word, and the success flag is high exactly when the write happened.
- R5: Load-linked (opcode 4) returns the word with the success flag low and records a reservation for that requester at that address. This replaces any earlier reservation the requester held.
- R6: Store-conditional (opcode 5) writes operand A only when the requester holds a valid reservation for the same address. The success flag reports whether it wrote, the old word is returned, and the requester's reservation is cleared whether or not the write happened.
- R7: Any write to a word (a store, a fetch-and-add, a successful compare-and-swap or a successful store-conditional) clears the reservations of all requesters at that word. A compare-and-swap that does not write leaves reservations intact.
- R8: Load (opcode 0) returns the word and does not write it. Store (opcode 1) writes operand A and returns the old word. Opcodes 6 and 7 behave as a load. For all three the success flag is low.
- R9: After reset every memory word reads 0, no reservation is held, no response is valid and no requester sees ready while none is valid.
- R10: Four requesters that each increment a word starting at 0 exactly once leave it at 4. This holds for fetch-and-add, for compare-and-swap retry loops and for load-linked / store-conditional retry loops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | N_REQ | Request valid, one bit per requester |
| req_ready | output | N_REQ | Request accepted when high with valid |
| req_op | input | 3*N_REQ | Opcode per requester (3 bits each) |
| req_addr | input | ADDR_W*N_REQ | Word address per requester |
| req_opa | input | DATA_W*N_REQ | Operand A: store data, addend, expected value |
| req_opb | input | DATA_W*N_REQ | Operand B: compare-and-swap new value |
| rsp_valid | output | 1 | Response valid for one cycle |
| rsp_id | output | clog2(N_REQ) | Requester the response belongs to |
| rsp_data | output | DATA_W | Value of the word before the operation |
| rsp_ok | output | 1 | Conditional operation succeeded |

## Verification
The bench builds the unit with four requesters, eight words and 16-bit data. Four requesters make three-way and four-way priority contests possible, and they let every requester break every other requester's link. With 16-bit words, the fetch-and-add wrap at the top of the range takes a single operation to reach. With only eight words, several reservations end up on the same address, and some sit on neighbouring addresses that must not be disturbed.

// File: rtl/atomic_pkg.sv
// Shared opcode encoding for the atomic memory operation unit.
// Assumes a 3-bit opcode field on every request channel.
package atomic_pkg;
    typedef enum logic [2:0] {
        OP_LOAD  = 3'd0,
        OP_STORE = 3'd1,
        OP_FADD  = 3'd2,
        OP_CAS   = 3'd3,
        OP_LL    = 3'd4,
        OP_SC    = 3'd5,
        OP_RSV6  = 3'd6,
        OP_RSV7  = 3'd7
    } amo_op_e;
endpackage

// File: rtl/amo_prio_arb.sv
// Fixed-priority arbiter: grants the lowest-numbered active request.
// Assumes the caller drops en while an operation is in flight.
module amo_prio_arb #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [N-1:0]  req,
    output logic [N-1:0]  gnt,
    output logic [IW-1:0] gnt_id
);
    // Scan from requester 0 upward and stop at the first active one.
    always_comb begin
        logic found;
        found  = 1'b0;
        gnt    = '0;
        gnt_id = '0;
        for (int i = 0; i < N; i++) begin
            if (en && req[i] && !found) begin
                gnt[i] = 1'b1;
                gnt_id = IW'(i);
                found  = 1'b1;
            end
        end
    end

    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt)); // R1
    AST_GNT_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~req) == '0); // R1
    AST_GNT_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt != '0) |-> ((req & (gnt - 1'b1)) == '0)); // R1
endmodule

// File: rtl/amo_exec.sv
// Combinational execute stage: decides whether and what to write, and the
// success flag, from the opcode, the old word and the reservation match.
// Assumes the old word is read in the same cycle the write is committed.
module amo_exec
    import atomic_pkg::*;
#(
    parameter int DW = 32
) (
    input  amo_op_e       op,
    input  logic [DW-1:0] old_val,
    input  logic [DW-1:0] opa,
    input  logic [DW-1:0] opb,
    input  logic          resv_hit,
    output logic          wr_en,
    output logic [DW-1:0] wr_data,
    output logic          ok
);
    // Per-opcode write decision and result flag.
    always_comb begin
        wr_en   = 1'b0;
        wr_data = opa;
        ok      = 1'b0;
        unique case (op)
            OP_STORE: wr_en = 1'b1;
            OP_FADD: begin
                wr_en   = 1'b1;
                wr_data = old_val + opa;
            end
            OP_CAS: begin
                wr_en   = (old_val == opa);
                wr_data = opb;
                ok      = (old_val == opa);
            end
            OP_SC: begin
                wr_en = resv_hit;
                ok    = resv_hit;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/amo_resv_table.sv
// Link reservation table: one valid bit and one address per requester.
// Assumes exec_en is high for exactly one cycle per executed operation.
module amo_resv_table
    import atomic_pkg::*;
#(
    parameter int N  = 4,
    parameter int IW = 2,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          exec_en,
    input  logic [IW-1:0] exec_id,
    input  amo_op_e       exec_op,
    input  logic [AW-1:0] exec_addr,
    input  logic          wr_en,
    output logic          hit
);
    logic [N-1:0]  v_q;
    logic [AW-1:0] a_q [N];

    // The issuing requester's reservation matches the executed address.
    assign hit = v_q[exec_id] && (a_q[exec_id] == exec_addr);

    // Clear on a write to the linked word, clear on own SC, set on own LL.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q <= '0;
            for (int i = 0; i < N; i++) a_q[i] <= '0;
        end else if (exec_en) begin
            for (int i = 0; i < N; i++) begin
                if (wr_en && v_q[i] && (a_q[i] == exec_addr)) v_q[i] <= 1'b0;
                if (exec_id == IW'(i) && exec_op == OP_SC) v_q[i] <= 1'b0;
                if (exec_id == IW'(i) && exec_op == OP_LL) begin
                    v_q[i] <= 1'b1;
                    a_q[i] <= exec_addr;
                end
            end
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_slot_chk
        AST_SC_DROPS_LINK: assert property (@(posedge clk) disable iff (!rst_n)
            (exec_en && exec_id == IW'(g) && exec_op == OP_SC) |=> !v_q[g]); // R6
        AST_LL_SETS_LINK: assert property (@(posedge clk) disable iff (!rst_n)
            (exec_en && exec_id == IW'(g) && exec_op == OP_LL)
            |=> (v_q[g] && a_q[g] == $past(exec_addr))); // R5
        AST_WRITE_BREAKS_LINK: assert property (@(posedge clk) disable iff (!rst_n)
            (exec_en && wr_en && v_q[g] && a_q[g] == exec_addr) |=> !v_q[g]); // R7
    end
endmodule

// File: rtl/atomic_unit.sv
// Atomic memory operation unit: arbitrates among requesters, captures one
// request, executes it as a single read-modify-write on the next edge and
// returns the old word. Assumes a small flop-based memory, reset to zero.
module atomic_unit
    import atomic_pkg::*;
#(
    parameter int N_REQ  = 4,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic [N_REQ-1:0]                        req_valid,
    output logic [N_REQ-1:0]                        req_ready,
    input  logic [3*N_REQ-1:0]                      req_op,
    input  logic [ADDR_W*N_REQ-1:0]                 req_addr,
    input  logic [DATA_W*N_REQ-1:0]                 req_opa,
    input  logic [DATA_W*N_REQ-1:0]                 req_opb,
    output logic                                    rsp_valid,
    output logic [((N_REQ > 1) ? $clog2(N_REQ) : 1)-1:0] rsp_id,
    output logic [DATA_W-1:0]                       rsp_data,
    output logic                                    rsp_ok
);
    localparam int IW    = (N_REQ > 1) ? $clog2(N_REQ) : 1;
    localparam int DEPTH = 1 << ADDR_W;

    logic [N_REQ-1:0]  gnt;
    logic [IW-1:0]     gnt_id;
    logic              busy_q;
    logic              accept;
    logic [IW-1:0]     cap_id;
    amo_op_e           cap_op;
    logic [ADDR_W-1:0] cap_addr;
    logic [DATA_W-1:0] cap_a;
    logic [DATA_W-1:0] cap_b;
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] old_val;
    logic              wr_en;
    logic [DATA_W-1:0] wr_data;
    logic              ok;
    logic              resv_hit;

    amo_prio_arb #(.N(N_REQ), .IW(IW)) arb_i (
        .clk(clk), .rst_n(rst_n), .en(!busy_q), .req(req_valid),
        .gnt(gnt), .gnt_id(gnt_id)
    );

    assign req_ready = gnt;
    assign accept    = |(req_valid & gnt);
    assign old_val   = mem_q[cap_addr];

    // Capture the granted request and hold it for the execute cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q   <= 1'b0;
            cap_id   <= '0;
            cap_op   <= OP_LOAD;
            cap_addr <= '0;
            cap_a    <= '0;
            cap_b    <= '0;
        end else if (busy_q) begin
            busy_q <= 1'b0;
        end else if (accept) begin
            busy_q   <= 1'b1;
            cap_id   <= gnt_id;
            cap_op   <= amo_op_e'(req_op[int'(gnt_id)*3 +: 3]);
            cap_addr <= req_addr[int'(gnt_id)*ADDR_W +: ADDR_W];
            cap_a    <= req_opa[int'(gnt_id)*DATA_W +: DATA_W];
            cap_b    <= req_opb[int'(gnt_id)*DATA_W +: DATA_W];
        end
    end

    amo_exec #(.DW(DATA_W)) exec_i (
        .op(cap_op), .old_val(old_val), .opa(cap_a), .opb(cap_b),
        .resv_hit(resv_hit), .wr_en(wr_en), .wr_data(wr_data), .ok(ok)
    );

    amo_resv_table #(.N(N_REQ), .IW(IW), .AW(ADDR_W)) resv_i (
        .clk(clk), .rst_n(rst_n), .exec_en(busy_q), .exec_id(cap_id),
        .exec_op(cap_op), .exec_addr(cap_addr), .wr_en(wr_en), .hit(resv_hit)
    );

    // Commit the write of the executing operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (busy_q && wr_en) begin
            mem_q[cap_addr] <= wr_data;
        end
    end

    // Register the response of the executing operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_id    <= '0;
            rsp_data  <= '0;
            rsp_ok    <= 1'b0;
        end else begin
            rsp_valid <= busy_q;
            if (busy_q) begin
                rsp_id   <= cap_id;
                rsp_data <= old_val;
                rsp_ok   <= ok;
            end
        end
    end

    AST_NO_READY_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (req_ready == '0)); // R2
    AST_RSP_TWO_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> ##2 (rsp_valid && rsp_id == $past(gnt_id, 2))); // R2
    AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R2
    AST_LOAD_KEEPS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && (cap_op == OP_LOAD || cap_op == OP_LL))
        |=> (mem_q[$past(cap_addr)] == $past(old_val))); // R8
endmodule

// File: tb/atomic_unit_tb.sv
// Bench: behavioural reference model stepped every clock and compared with
// the ready vector and the response channel.
module atomic_unit_tb_top;
    localparam int N  = 4;
    localparam int AW = 3;
    localparam int DW = 16;
    localparam int IW = 2;

    logic clk = 1'b0;
    always #4 clk = ~clk;
    logic rst_n;

    logic [N-1:0]    req_valid, req_ready;
    logic [3*N-1:0]  req_op;
    logic [AW*N-1:0] req_addr;
    logic [DW*N-1:0] req_opa, req_opb;
    logic            rsp_valid, rsp_ok;
    logic [IW-1:0]   rsp_id;
    logic [DW-1:0]   rsp_data;

    atomic_unit #(.N_REQ(N), .ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_opa(req_opa), .req_opb(req_opb),
        .rsp_valid(rsp_valid), .rsp_id(rsp_id), .rsp_data(rsp_data), .rsp_ok(rsp_ok)
    );

    logic          d_v [N];
    logic [2:0]    d_op [N];
    logic [AW-1:0] d_addr [N];
    logic [DW-1:0] d_a [N];
    logic [DW-1:0] d_b [N];

    always_comb begin
        for (int i = 0; i < N; i++) begin
            req_valid[i]           = d_v[i];
            req_op[i*3 +: 3]       = d_op[i];
            req_addr[i*AW +: AW]   = d_addr[i];
            req_opa[i*DW +: DW]    = d_a[i];
            req_opb[i*DW +: DW]    = d_b[i];
        end
    end

    // reference model state
    logic [DW-1:0] m_mem [1<<AW];
    bit            m_rv [N];
    logic [AW-1:0] m_ra [N];
    bit            m_busy;
    int            m_id;
    logic [2:0]    m_op;
    logic [AW-1:0] m_addr;
    logic [DW-1:0] m_a, m_b;
    bit            m_rsp_v;
    int            m_rsp_id;
    logic [DW-1:0] m_rsp_d;
    bit            m_rsp_ok;

    logic [DW-1:0] got_d [N];
    bit            got_ok [N];
    int checks = 0;
    int fails  = 0;

    task automatic chk_eq(string rq, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    task automatic model_reset();
        for (int i = 0; i < (1 << AW); i++) m_mem[i] = '0;
        for (int i = 0; i < N; i++) begin m_rv[i] = 0; m_ra[i] = '0; end
        m_busy = 0; m_rsp_v = 0;
    endtask

    // One clock: check ready, advance model, check response after the edge.
    task automatic step(string rq);
        int win;
        logic [N-1:0] exp_rdy;
        logic [DW-1:0] old, wd;
        bit wr, ok;
        win = -1;
        exp_rdy = '0;
        if (!m_busy)
            for (int i = 0; i < N; i++) if (d_v[i] && win < 0) win = i;
        if (win >= 0) exp_rdy[win] = 1'b1;
        #1;
        chk_eq(rq, "ready", 32'(req_ready), 32'(exp_rdy));
        m_rsp_v = 0;
        if (m_busy) begin
            old = m_mem[m_addr]; wr = 0; ok = 0; wd = m_a;
            case (m_op)
                3'd1: wr = 1;
                3'd2: begin wr = 1; wd = old + m_a; end
                3'd3: if (old == m_a) begin wr = 1; ok = 1; wd = m_b; end
                3'd5: if (m_rv[m_id] && m_ra[m_id] == m_addr) begin wr = 1; ok = 1; end
                default: ;
            endcase
            if (wr) begin
                m_mem[m_addr] = wd;
                for (int j = 0; j < N; j++) if (m_rv[j] && m_ra[j] == m_addr) m_rv[j] = 0;
            end
            if (m_op == 3'd5) m_rv[m_id] = 0;
            if (m_op == 3'd4) begin m_rv[m_id] = 1; m_ra[m_id] = m_addr; end
            m_rsp_v = 1; m_rsp_id = m_id; m_rsp_d = old; m_rsp_ok = ok;
            m_busy = 0;
        end else if (win >= 0) begin
            m_busy = 1; m_id = win; m_op = d_op[win]; m_addr = d_addr[win];
            m_a = d_a[win]; m_b = d_b[win];
        end
        @(posedge clk);
        @(negedge clk);
        if (win >= 0) d_v[win] = 1'b0;
        chk_eq(rq, "rsp_valid", 32'(rsp_valid), 32'(m_rsp_v));
        if (m_rsp_v) begin
            chk_eq(rq, "rsp_id", 32'(rsp_id), 32'(m_rsp_id));
            chk_eq(rq, "rsp_data", 32'(rsp_data), 32'(m_rsp_d));
            chk_eq(rq, "rsp_ok", 32'(rsp_ok), 32'(m_rsp_ok));
            got_d[m_rsp_id] = rsp_data;
            got_ok[m_rsp_id] = rsp_ok;
        end
    endtask

    task automatic post(int id, logic [2:0] op, logic [AW-1:0] ad, logic [DW-1:0] a, logic [DW-1:0] b);
        d_v[id] = 1'b1; d_op[id] = op; d_addr[id] = ad; d_a[id] = a; d_b[id] = b;
    endtask

    task automatic drain(string rq);
        bit any;
        do begin
            any = m_busy;
            for (int i = 0; i < N; i++) if (d_v[i]) any = 1;
            if (any) step(rq);
        end while (any);
    endtask

    task automatic issue(string rq, int id, logic [2:0] op, logic [AW-1:0] ad,
                         logic [DW-1:0] a, logic [DW-1:0] b);
        post(id, op, ad, a, b);
        drain(rq);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [DW-1:0] v;
        int tries;
        for (int i = 0; i < N; i++) begin
            d_v[i] = 0; d_op[i] = '0; d_addr[i] = '0; d_a[i] = '0; d_b[i] = '0;
        end
        rst_n = 1'b0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9: idle state and zeroed memory
        step("R9");
        issue("R9", 0, 3'd0, 3, 0, 0);
        chk_eq("R9", "word 3 after reset", 32'(got_d[0]), 0);
        issue("R9", 3, 3'd5, 3, 16'h77, 0);
        chk_eq("R9", "sc without link", 32'(got_ok[3]), 0);

        // R8: store, load, reserved opcodes
        issue("R8", 2, 3'd1, 1, 16'h1234, 0);
        issue("R8", 1, 3'd0, 1, 0, 0);
        chk_eq("R8", "load after store", 32'(got_d[1]), 32'h1234);
        issue("R8", 1, 3'd7, 1, 16'h9999, 16'h9999);
        issue("R8", 0, 3'd6, 1, 16'h5555, 0);
        issue("R8", 1, 3'd0, 1, 0, 0);
        chk_eq("R8", "reserved op wrote nothing", 32'(got_d[1]), 32'h1234);

        // R3: fetch-and-add and wrap
        issue("R3", 0, 3'd2, 1, 5, 0);
        chk_eq("R3", "fadd old", 32'(got_d[0]), 32'h1234);
        issue("R3", 0, 3'd1, 2, 16'hFFFE, 0);
        issue("R3", 3, 3'd2, 2, 3, 0);
        issue("R3", 3, 3'd0, 2, 0, 0);
        chk_eq("R3", "fadd wrap", 32'(got_d[3]), 1);

        // R4: compare-and-swap
        issue("R4", 1, 3'd1, 4, 0, 0);
        issue("R4", 1, 3'd3, 4, 7, 9);
        chk_eq("R4", "cas miss flag", 32'(got_ok[1]), 0);
        issue("R4", 1, 3'd3, 4, 0, 9);
        chk_eq("R4", "cas hit flag", 32'(got_ok[1]), 1);
        issue("R4", 2, 3'd0, 4, 0, 0);
        chk_eq("R4", "cas new value", 32'(got_d[2]), 9);

        // R1 / R2: contention, one acceptance per two cycles
        post(3, 3'd0, 4, 0, 0); post(1, 3'd0, 1, 0, 0); post(2, 3'd2, 4, 1, 0);
        drain("R1");
        post(0, 3'd2, 5, 1, 0); post(1, 3'd2, 5, 2, 0);
        post(2, 3'd2, 5, 4, 0); post(3, 3'd2, 5, 8, 0);
        drain("R2");
        issue("R2", 0, 3'd0, 5, 0, 0);
        chk_eq("R2", "all four applied", 32'(got_d[0]), 15);

        // R5 / R6: link set, replace, drop on SC
        issue("R5", 1, 3'd4, 3, 0, 0);
        issue("R6", 1, 3'd5, 3, 16'h55, 0);
        chk_eq("R6", "sc with link", 32'(got_ok[1]), 1);
        issue("R6", 1, 3'd5, 3, 16'h66, 0);
        chk_eq("R6", "second sc fails", 32'(got_ok[1]), 0);
        issue("R5", 1, 3'd4, 3, 0, 0);
        issue("R5", 1, 3'd4, 4, 0, 0);
        issue("R5", 1, 3'd5, 3, 16'h77, 0);
        chk_eq("R5", "replaced link", 32'(got_ok[1]), 0);
        issue("R6", 1, 3'd5, 4, 16'h77, 0);
        chk_eq("R6", "failed sc dropped link", 32'(got_ok[1]), 0);

        // R7: writes break links, unrelated or failed writes do not
        issue("R7", 0, 3'd4, 6, 0, 0);
        issue("R7", 1, 3'd1, 6, 16'hAA, 0);
        issue("R7", 0, 3'd5, 6, 1, 0);
        chk_eq("R7", "store broke link", 32'(got_ok[0]), 0);
        issue("R7", 0, 3'd4, 6, 0, 0);
        issue("R7", 1, 3'd1, 7, 16'hBB, 0);
        issue("R7", 1, 3'd3, 6, 16'h1, 16'h2);
        issue("R7", 0, 3'd5, 6, 16'hCC, 0);
        chk_eq("R7", "link survives", 32'(got_ok[0]), 1);
        issue("R7", 0, 3'd4, 6, 0, 0);
        issue("R7", 2, 3'd4, 6, 0, 0);
        issue("R7", 3, 3'd2, 6, 1, 0);
        issue("R7", 2, 3'd5, 6, 5, 0);
        chk_eq("R7", "fadd broke link", 32'(got_ok[2]), 0);
        issue("R7", 0, 3'd5, 6, 5, 0);
        chk_eq("R7", "fadd broke second link", 32'(got_ok[0]), 0);

        // R10: four increments with each primitive
        issue("R10", 0, 3'd1, 7, 0, 0);
        for (int r = 0; r < N; r++) post(r, 3'd2, 7, 1, 0);
        drain("R10");
        issue("R10", 0, 3'd0, 7, 0, 0);
        chk_eq("R10", "fadd total", 32'(got_d[0]), 4);

        issue("R10", 0, 3'd1, 6, 0, 0);
        for (int r = 0; r < N; r++) post(r, 3'd3, 6, 0, 1);
        drain("R10");
        for (int r = 1; r < N; r++) begin
            tries = 0;
            do begin
                issue("R10", r, 3'd0, 6, 0, 0);
                v = got_d[r];
                issue("R10", r, 3'd3, 6, v, v + 1'b1);
                tries++;
            end while (!got_ok[r] && tries < 8);
        end
        issue("R10", 0, 3'd0, 6, 0, 0);
        chk_eq("R10", "cas total", 32'(got_d[0]), 4);

        issue("R10", 0, 3'd1, 0, 0, 0);
        for (int r = 0; r < N; r++) post(r, 3'd4, 0, 0, 0);
        drain("R10");
        for (int r = 0; r < N; r++) post(r, 3'd5, 0, 1, 0);
        drain("R10");
        for (int r = 1; r < N; r++) begin
            tries = 0;
            do begin
                issue("R10", r, 3'd4, 0, 0, 0);
                v = got_d[r];
                issue("R10", r, 3'd5, 0, v + 1'b1, 0);
                tries++;
            end while (!got_ok[r] && tries < 8);
        end
        issue("R10", 0, 3'd0, 0, 0, 0);
        chk_eq("R10", "ll/sc total", 32'(got_d[0]), 4);

        summary();
        $finish;
    end
endmodule